// File: doc/BRIEF.md
# Timer Compare Output Unit

This block holds a 16-bit compare value and a 4-bit operating mode. It compares the value against the count of one of two external 16-bit timers. When the selected count first becomes equal to the compare value, the unit acts on an output latch: it sets the latch, clears it, toggles it, or leaves it alone, depending on the mode. The same event raises a sticky interrupt flag.

In the event-trigger mode, a match emits a one-cycle reset pulse to the selected timer. The compare value then works as that timer's period. When the feature is built in and the converter reports itself enabled, the pulse also carries an A/D start strobe.

An external direction bit decides whether the latch drives the pin or the pin is released. Writing an all-zero control word returns the latch to low. The timers and the converter sit outside this block.

Top module: `cmp_out_unit`

## Requirements
- R1: The 16-bit compare value written through `val_we`/`val_wdata` is compared against timer A's count when `tmr_sel` is 0 and against timer B's count when `tmr_sel` is 1.
- R2: A match event happens only in a compare mode (codes 4'b0010, 4'b1000, 4'b1001, 4'b1010, 4'b1011). It lasts one cycle and occurs in the cycle when equality first becomes true. A count that stays at the matching value causes no further events. Its effects appear on the outputs after the next rising clock edge.
- R3: On a match event, mode 4'b1000 sets the latch, 4'b1001 clears it and 4'b0010 inverts it.
- R4: Every match event sets `irq_flag`. The flag stays set until `flag_clr` is high. A clear in the same cycle as a match event leaves the flag set.
- R5: In mode 4'b1010, a match event sets only the flag and leaves the latch unchanged.
- R6: In mode 4'b1011, a match event gives a one-cycle pulse on `tmr_a_rst` (select 0) or `tmr_b_rst` (select 1), never on both.
- R7: With `ADC_TRIG_EN`=1, a mode 4'b1011 match event also pulses `adc_start` for one cycle, but only if `adc_enabled` is high in that cycle.
- R8: A control write of 4'b0000 forces the latch low after the write edge, and mode 0000 then takes no action.
- R9: `pin_oe` equals `pin_dir_out`. `pin_out` shows the latch while `pin_dir_out` is 1 and is 0 while it is 0. The latch keeps its value across release.
- R10: Control codes outside the compare set produce no match events: neither the latch nor the flag changes.
- R11: After synchronous active-low reset the mode is 0000, the compare value is 0, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| val_we | input | 1 | Compare value write enable |
| val_wdata | input | 16 | Compare value write data |
| ctl_we | input | 1 | Control (mode) write enable |
| ctl_wdata | input | 4 | Control mode write data |
| tmr_sel | input | 1 | Time base select: 0 timer A, 1 timer B |
| tmr_a_cnt | input | 16 | Timer A count |
| tmr_b_cnt | input | 16 | Timer B count |
| pin_dir_out | input | 1 | Direction bit, 1 drives the pin |
| adc_enabled | input | 1 | Converter enabled indication |
| flag_clr | input | 1 | Interrupt flag clear |
| pin_out | output | 1 | Pin data |
| pin_oe | output | 1 | Pin output enable |
| irq_flag | output | 1 | Sticky interrupt flag |
| tmr_a_rst | output | 1 | Reset pulse to timer A |
| tmr_b_rst | output | 1 | Reset pulse to timer B |
| adc_start | output | 1 | A/D conversion start strobe |

## Verification
Two things can happen in the same cycle: a software flag clear and a new match event that sets the flag. The bench provokes this by raising `flag_clr` in the cycle when the timer count steps onto the compare value, while in toggle mode. It expects the flag to read set and the latch to have inverted after that edge. A second collision is a timer held at the match value while the flag is being cleared. Here the bench expects the flag to drop and no second trigger pulse to appear.

// File: rtl/cmp_pkg.sv
// Package: shared mode codes and the predicate that says which codes compare.
// Assumes a 4-bit control field; any unlisted code is inert.
package cmp_pkg;
    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        MODE_OFF    = 4'b0000,
        MODE_TOGGLE = 4'b0010,
        MODE_SET    = 4'b1000,
        MODE_CLR    = 4'b1001,
        MODE_SWINT  = 4'b1010,
        MODE_EVENT  = 4'b1011
    } cmp_mode_e;

    // True for codes that enable the comparator.
    function automatic logic mode_compares(input logic [MODE_W-1:0] m);
        case (m)
            MODE_TOGGLE, MODE_SET, MODE_CLR, MODE_SWINT, MODE_EVENT: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/cmp_regs.sv
// Module: compare value and mode registers.
// Assumes single-cycle writes; zero_wr flags an all-zero control write this cycle.
module cmp_regs
    import cmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              val_we,
    input  logic [CNT_W-1:0]  val_wdata,
    input  logic              ctl_we,
    input  logic [MODE_W-1:0] ctl_wdata,
    output logic [CNT_W-1:0]  cmp_val,
    output logic [MODE_W-1:0] mode,
    output logic              zero_wr
);
    // Hold the compare value.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_val <= '0;
        else if (val_we) cmp_val <= val_wdata;
    end

    // Hold the operating mode.
    always_ff @(posedge clk) begin
        if (!rst_n)      mode <= MODE_OFF;
        else if (ctl_we) mode <= ctl_wdata;
    end

    // Flag an all-zero control write for the latch clear.
    always_comb zero_wr = ctl_we && (ctl_wdata == MODE_OFF);
endmodule

// File: rtl/cmp_match_det.sv
// Module: picks the time base, tests equality and emits a one-cycle hit
// on the first cycle of equality. Assumes timer counts synchronous to clk.
module cmp_match_det #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             sel,
    input  logic [CNT_W-1:0] cnt_a,
    input  logic [CNT_W-1:0] cnt_b,
    input  logic [CNT_W-1:0] cmp_val,
    output logic             hit
);
    logic [CNT_W-1:0] cnt_sel;
    logic             eq_now;
    logic             eq_q;

    // Route the selected timer count.
    always_comb cnt_sel = sel ? cnt_b : cnt_a;

    // Level equality, gated by the compare enable.
    always_comb eq_now = en && (cnt_sel == cmp_val);

    // Remember last cycle's equality for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) eq_q <= 1'b0;
        else        eq_q <= eq_now;
    end

    // Rising edge of equality is the match event.
    always_comb hit = eq_now && !eq_q;
endmodule

// File: rtl/cmp_action.sv
// Module: applies the mode to the latch, keeps the sticky flag and emits
// timer reset and converter start pulses. Assumes hit is a one-cycle event.
module cmp_action
    import cmp_pkg::*;
#(
    parameter bit ADC_TRIG_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [MODE_W-1:0] mode,
    input  logic              sel,
    input  logic              zero_wr,
    input  logic              adc_en,
    input  logic              flag_clr,
    output logic              latch_q,
    output logic              flag_q,
    output logic              rst_a_q,
    output logic              rst_b_q,
    output logic              adc_q
);
    logic ev;

    // Special event condition.
    always_comb ev = hit && (mode == MODE_EVENT);

    // Output latch: zero write wins, else the mode's action on a hit.
    always_ff @(posedge clk) begin
        if (!rst_n)       latch_q <= 1'b0;
        else if (zero_wr) latch_q <= 1'b0;
        else if (hit) begin
            case (mode)
                MODE_SET:    latch_q <= 1'b1;
                MODE_CLR:    latch_q <= 1'b0;
                MODE_TOGGLE: latch_q <= ~latch_q;
                default:     latch_q <= latch_q;
            endcase
        end
    end

    // Sticky flag: a hit beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (hit)      flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    // Timer reset pulses toward the selected time base.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_a_q <= 1'b0;
            rst_b_q <= 1'b0;
        end else begin
            rst_a_q <= ev && !sel;
            rst_b_q <= ev && sel;
        end
    end

    generate
        if (ADC_TRIG_EN) begin : g_adc
            // Converter start pulse when the converter is ready.
            always_ff @(posedge clk) begin
                if (!rst_n) adc_q <= 1'b0;
                else        adc_q <= ev && adc_en;
            end

            assert_adc_with_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
                adc_q |-> (rst_a_q || rst_b_q));
        end else begin : g_no_adc
            assign adc_q = 1'b0;
            logic unused_adc;
            assign unused_adc = adc_en;
        end
    endgenerate

    assert_hit_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag_q);

    assert_swint_latch_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && mode == MODE_SWINT && !zero_wr) |=> $stable(latch_q));

    assert_event_resets_timer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ev |=> (rst_a_q || rst_b_q));

    assert_single_timer_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rst_a_q, rst_b_q}));

    assert_zero_write_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        zero_wr |=> !latch_q);
endmodule

// File: rtl/cmp_out_unit.sv
// Module: top of the timer compare output unit. Wires registers, match
// detector and action logic and gates the pin with the direction bit.
// Assumes all inputs are synchronous to clk.
module cmp_out_unit
    import cmp_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter bit ADC_TRIG_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              val_we,
    input  logic [CNT_W-1:0]  val_wdata,
    input  logic              ctl_we,
    input  logic [MODE_W-1:0] ctl_wdata,
    input  logic              tmr_sel,
    input  logic [CNT_W-1:0]  tmr_a_cnt,
    input  logic [CNT_W-1:0]  tmr_b_cnt,
    input  logic              pin_dir_out,
    input  logic              adc_enabled,
    input  logic              flag_clr,
    output logic              pin_out,
    output logic              pin_oe,
    output logic              irq_flag,
    output logic              tmr_a_rst,
    output logic              tmr_b_rst,
    output logic              adc_start
);
    logic [CNT_W-1:0]  cmp_val;
    logic [MODE_W-1:0] mode;
    logic              zero_wr;
    logic              hit;
    logic              latch_q;

    cmp_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .val_we(val_we), .val_wdata(val_wdata),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .cmp_val(cmp_val), .mode(mode), .zero_wr(zero_wr)
    );

    cmp_match_det #(.CNT_W(CNT_W)) u_det (
        .clk(clk), .rst_n(rst_n),
        .en(mode_compares(mode)), .sel(tmr_sel),
        .cnt_a(tmr_a_cnt), .cnt_b(tmr_b_cnt),
        .cmp_val(cmp_val), .hit(hit)
    );

    cmp_action #(.ADC_TRIG_EN(ADC_TRIG_EN)) u_act (
        .clk(clk), .rst_n(rst_n),
        .hit(hit), .mode(mode), .sel(tmr_sel), .zero_wr(zero_wr),
        .adc_en(adc_enabled), .flag_clr(flag_clr),
        .latch_q(latch_q), .flag_q(irq_flag),
        .rst_a_q(tmr_a_rst), .rst_b_q(tmr_b_rst), .adc_q(adc_start)
    );

    // Drive the pin only when the direction bit selects output.
    always_comb begin
        pin_oe  = pin_dir_out;
        pin_out = pin_dir_out && latch_q;
    end

    assert_inert_mode_no_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_compares(mode) && !irq_flag) |=> !irq_flag);
endmodule

// File: tb/tb_cmp_out_unit.sv
module tb_cmp_out_unit;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;
    localparam int NV = 25;

    typedef struct packed {
        logic       wr;
        logic [3:0] mode;
        logic       sel;
        logic [W-1:0] ca;
        logic [W-1:0] cb;
        logic       clr;
        logic       dir;
        logic       aden;
        logic [5:0] exp;  // pin, oe, flag, rst_a, rst_b, adc
    } vec_t;

    // Each row is applied for one clock; exp is sampled after that edge.
    // Compare value is 16'h0010 throughout the table.
    localparam vec_t VEC [NV] = '{
        '{1'b1, 4'h8, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0, 6'b010000}, // 0  R11 mode0 idle
        '{1'b0, 4'h8, 1'b0, 16'h000F, 16'h0000, 1'b0, 1'b1, 1'b0, 6'b010000}, // 1  R1 no match
        '{1'b0, 4'h8, 1'b0, 16'h0010, 16'h0000, 1'b0, 1'b1, 1'b0, 6'b111000}, // 2  R3 set
        '{1'b0, 4'h8, 1'b0, 16'h0010, 16'h0000, 1'b1, 1'b1, 1'b0, 6'b110000}, // 3  R2 held, R4 clear
        '{1'b1, 4'h9, 1'b0, 16'h0011, 16'h0000, 1'b0, 1'b1, 1'b0, 6'b110000}, // 4
        '{1'b0, 4'h9, 1'b0, 16'h0010, 16'h0000, 1'b0, 1'b1, 1'b0, 6'b011000}, // 5  R3 clear
        '{1'b1, 4'h2, 1'b0, 16'h0011, 16'h0000, 1'b1, 1'b1, 1'b0, 6'b010000}, // 6
        '{1'b0, 4'h2, 1'b0, 16'h0010, 16'h0000, 1'b0, 1'b1, 1'b0, 6'b111000}, // 7  R3 toggle
        '{1'b0, 4'h2, 1'b0, 16'h0011, 16'h0000, 1'b0, 1'b1, 1'b0, 6'b111000}, // 8
        '{1'b0, 4'h2, 1'b0, 16'h0010, 16'h0000, 1'b1, 1'b1, 1'b0, 6'b011000}, // 9  R4 clear+match
        '{1'b1, 4'hA, 1'b0, 16'h0011, 16'h0000, 1'b1, 1'b1, 1'b0, 6'b010000}, // 10
        '{1'b0, 4'hA, 1'b0, 16'h0010, 16'h0000, 1'b0, 1'b1, 1'b0, 6'b011000}, // 11 R5 flag only
        '{1'b1, 4'hB, 1'b1, 16'h0011, 16'h0005, 1'b1, 1'b1, 1'b0, 6'b010000}, // 12
        '{1'b0, 4'hB, 1'b1, 16'h0010, 16'h0010, 1'b0, 1'b1, 1'b1, 6'b011011}, // 13 R6 R7 timer B
        '{1'b0, 4'hB, 1'b1, 16'h0010, 16'h0010, 1'b1, 1'b1, 1'b1, 6'b010000}, // 14 R2 no retrigger
        '{1'b0, 4'hB, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b1, 6'b010000}, // 15
        '{1'b0, 4'hB, 1'b0, 16'h0010, 16'h0000, 1'b0, 1'b1, 1'b0, 6'b011100}, // 16 R6 timer A, R7 no adc
        '{1'b1, 4'h8, 1'b0, 16'h0011, 16'h0000, 1'b1, 1'b1, 1'b0, 6'b010000}, // 17
        '{1'b0, 4'h8, 1'b0, 16'h0010, 16'h0000, 1'b0, 1'b1, 1'b0, 6'b111000}, // 18
        '{1'b0, 4'h8, 1'b0, 16'h0011, 16'h0000, 1'b0, 1'b0, 1'b0, 6'b001000}, // 19 R9 released
        '{1'b0, 4'h8, 1'b0, 16'h0011, 16'h0000, 1'b0, 1'b1, 1'b0, 6'b111000}, // 20 R9 latch kept
        '{1'b1, 4'h0, 1'b0, 16'h0011, 16'h0000, 1'b1, 1'b1, 1'b0, 6'b010000}, // 21 R8 zero write
        '{1'b0, 4'h0, 1'b0, 16'h0010, 16'h0000, 1'b0, 1'b1, 1'b0, 6'b010000}, // 22 R8 mode0 inert
        '{1'b1, 4'h5, 1'b0, 16'h0011, 16'h0000, 1'b0, 1'b1, 1'b0, 6'b010000}, // 23
        '{1'b0, 4'h5, 1'b0, 16'h0010, 16'h0000, 1'b0, 1'b1, 1'b0, 6'b010000}  // 24 R10 inert code
    };

    logic clk = 1'b0;
    logic rst_n;
    logic val_we, ctl_we, tmr_sel, pin_dir_out, adc_enabled, flag_clr;
    logic [W-1:0] val_wdata, tmr_a_cnt, tmr_b_cnt;
    logic [3:0] ctl_wdata;
    logic pin_out, pin_oe, irq_flag, tmr_a_rst, tmr_b_rst, adc_start;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_out_unit dut (
        .clk(clk), .rst_n(rst_n),
        .val_we(val_we), .val_wdata(val_wdata),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .tmr_sel(tmr_sel), .tmr_a_cnt(tmr_a_cnt), .tmr_b_cnt(tmr_b_cnt),
        .pin_dir_out(pin_dir_out), .adc_enabled(adc_enabled), .flag_clr(flag_clr),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_flag(irq_flag),
        .tmr_a_rst(tmr_a_rst), .tmr_b_rst(tmr_b_rst), .adc_start(adc_start)
    );

    function automatic logic [5:0] outs();
        return {pin_out, pin_oe, irq_flag, tmr_a_rst, tmr_b_rst, adc_start};
    endfunction

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic idle_inputs();
        val_we = 0; val_wdata = '0; ctl_we = 0; ctl_wdata = '0;
        tmr_sel = 0; tmr_a_cnt = '0; tmr_b_cnt = '0;
        pin_dir_out = 0; adc_enabled = 0; flag_clr = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog actual hung expected finish");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        idle_inputs();
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R11 reset state", outs(), 6'b000000);
        rst_n = 1'b1;

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            ctl_we = VEC[i].wr; ctl_wdata = VEC[i].mode;
            val_we = VEC[i].wr; val_wdata = 16'h0010;
            tmr_sel = VEC[i].sel; tmr_a_cnt = VEC[i].ca; tmr_b_cnt = VEC[i].cb;
            flag_clr = VEC[i].clr; pin_dir_out = VEC[i].dir; adc_enabled = VEC[i].aden;
            @(posedge clk);
            @(negedge clk);
            check($sformatf("row %0d", i), outs(), VEC[i].exp);
        end

        // R1 boundary: all-ones compare value on timer B.
        idle_inputs();
        pin_dir_out = 1; tmr_sel = 1; tmr_b_cnt = 16'hFFFE;
        ctl_we = 1; ctl_wdata = 4'h8; val_we = 1; val_wdata = 16'hFFFF; flag_clr = 1;
        @(posedge clk); @(negedge clk);
        ctl_we = 0; val_we = 0; flag_clr = 0;
        check("R1 near miss at FFFE", outs(), 6'b010000);
        tmr_b_cnt = 16'hFFFF; tmr_a_cnt = 16'hFFFF;
        @(posedge clk); @(negedge clk);
        check("R1 match at FFFF", outs(), 6'b111000);

        // R7 disabled converter: timer A event with adc_enabled low was row 16;
        // here timer A event with adc_enabled high.
        ctl_we = 1; ctl_wdata = 4'hB; val_we = 1; val_wdata = 16'h0100;
        tmr_sel = 0; tmr_a_cnt = 16'h0000; flag_clr = 1;
        @(posedge clk); @(negedge clk);
        ctl_we = 0; val_we = 0; flag_clr = 0; adc_enabled = 1; tmr_a_cnt = 16'h0100;
        @(posedge clk); @(negedge clk);
        check("R7 adc start with timer A", outs(), 6'b111101);

        // R11 reset mid-run clears latch and flag.
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        pin_dir_out = 1;
        check("R11 reset mid-run", outs(), 6'b010000);
        rst_n = 1'b1;

        finish_run();
    end
endmodule